// File: doc/BRIEF.md
# Programmable External Interrupt Front End

This block watches 24 external interrupt lines and turns activity on them into requests for a main interrupt controller. Each line has a 3-bit trigger code. The code selects one of five conditions: a low level, a high level, a falling edge, a rising edge, or either edge. Every line is brought into the clock domain through a two-flop synchronizer before it is checked.

The four lowest lines go straight to the controller as four request outputs, one per line, without being latched. The upper lines, 4 to 23, are latched in a pending register. Software clears this register by writing ones to it. A per-line mask decides which pending bits reach the two aggregated request outputs. The first aggregated output covers lines 4 to 7 and the second covers lines 8 to 23. Software programs trigger codes, masks and clears through a small synchronous register port. A read returns its data one clock after the request.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, every trigger code reads as 0 (low level). The mask reads 0x00FFFFF0. Pending reads 0, and both aggregated outputs and all direct outputs are low. The synchronizers reset to the idle-high level.
- R2: Trigger codes sit in three registers at addresses 0, 1 and 2. Line n uses register n/8, bits 4*(n%8)+2 down to 4*(n%8). Bit 3 of each nibble is not stored and reads as 0.
- R3: Code 000 (low level) and code 001 (high level) set the line's pending bit on every cycle the synchronized level matches. After a clear, the bit sets again while the level persists.
- R4: Codes 01x detect falling edges, codes 10x detect rising edges, and codes 11x detect both edges. Bit 0 of an edge code has no effect. The opposite transition sets nothing.
- R5: The pending register is at address 4 and is write-one-to-clear. A written 1 clears the bit and a written 0 leaves it as it is. Bits 0 to 3 always read 0. A detection in the same cycle as a clear wins.
- R6: The mask register is at address 3. Bit n set to 1 blocks line n from its aggregated output, but line n's pending bit is still recorded.
- R7: grp_lo_req_o is the OR over lines 4 to 7 of pending AND NOT mask. grp_hi_req_o is the same OR over lines 8 to 23. Both follow the registers with no extra delay.
- R8: Lines 0 to 3 drive direct_req_o. An edge event gives a one-cycle pulse, and a level match holds the output high. A pin change reaches the output, and also a pending bit, at the third rising clock edge after the change. Lines 0 to 3 never touch pending or the aggregated outputs.
- R9: bus_rdata is updated only on a read request and is valid in the cycle after it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | External interrupt lines |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| direct_req_o | output | 4 | Requests from lines 0 to 3 |
| grp_lo_req_o | output | 1 | Aggregated request, lines 4 to 7 |
| grp_hi_req_o | output | 1 | Aggregated request, lines 8 to 23 |

## Verification
The hardest case to reach from the ports is a level-mode line whose pending bit sets again right after software clears it. This needs a line that holds its active level through the clear. It also needs the clear to arrive after the synchronizer has already passed that level. The bench holds a line low under code 000 for several cycles, issues the clear, and reads the pending register back. The masked-but-recorded case is reached in a similar way. The bench pulses a masked line, reads its pending bit while the aggregated output stays low, and then unmasks it to see the output rise.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CODE_W = 3;
  localparam int SLOT_W = 4;

  typedef enum logic [2:0] {
    TRIG_LOW,
    TRIG_HIGH,
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH
  } trig_e;

  function automatic trig_e decode_trig(input logic [CODE_W-1:0] code);
    trig_e t;
    case (code[2:1])
      2'b00:   t = code[0] ? TRIG_HIGH : TRIG_LOW;
      2'b01:   t = TRIG_FALL;
      2'b10:   t = TRIG_RISE;
      default: t = TRIG_BOTH;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ext_irq_pin_sync.sv
module ext_irq_pin_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, lvl_q, prev_q;
  logic [WIDTH-1:0] meta_d, lvl_d, prev_d;

  always_comb begin
    meta_d = pin_i;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      lvl_q  <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0]             lvl_i,
  input  logic [NUM_PINS-1:0]             prev_i,
  input  logic [NUM_PINS-1:0][CODE_W-1:0] code_i,
  output logic [NUM_PINS-1:0]             hit_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[g] & ~prev_i[g];
    assign fall = ~lvl_i[g] & prev_i[g];
    always_comb begin
      case (decode_trig(code_i[g]))
        TRIG_LOW:  hit_o[g] = ~lvl_i[g];
        TRIG_HIGH: hit_o[g] = lvl_i[g];
        TRIG_FALL: hit_o[g] = fall;
        TRIG_RISE: hit_o[g] = rise;
        default:   hit_o[g] = rise | fall;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS       = 24,
  parameter int NUM_DIRECT     = 4,
  parameter int FIELDS_PER_REG = 8,
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_en,
  input  logic                            bus_we,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]             hit_i,
  output logic [NUM_PINS-1:0][CODE_W-1:0] code_o,
  output logic [NUM_PINS-1:0]             mask_o,
  output logic [NUM_PINS-1:0]             pend_o
);
  localparam int NUM_CFG = (NUM_PINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_CFG);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NUM_CFG + 1);
  localparam logic [NUM_PINS-1:0] EXT_BITS =
    {{(NUM_PINS-NUM_DIRECT){1'b1}}, {NUM_DIRECT{1'b0}}};

  logic [NUM_PINS-1:0][CODE_W-1:0] code_q, code_d;
  logic [NUM_PINS-1:0]             mask_q, mask_d;
  logic [NUM_PINS-1:0]             pend_q, pend_d;
  logic [NUM_PINS-1:0]             clr_bits;
  logic [DATA_W-1:0]               rd_val, rdata_q;
  logic                            wr_req, rd_req, cfg_en, mask_en;

  assign wr_req  = bus_en & bus_we;
  assign rd_req  = bus_en & ~bus_we;
  assign cfg_en  = wr_req & (bus_addr < A_MASK);
  assign mask_en = wr_req & (bus_addr == A_MASK);

  always_comb begin
    code_d = code_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == ADDR_W'(p / FIELDS_PER_REG))
        code_d[p] = bus_wdata[SLOT_W*(p % FIELDS_PER_REG) +: CODE_W];
    end
  end

  always_comb begin
    mask_d   = bus_wdata[NUM_PINS-1:0] & EXT_BITS;
    clr_bits = (wr_req && bus_addr == A_PEND) ? bus_wdata[NUM_PINS-1:0] : '0;
    pend_d   = ((pend_q & ~clr_bits) | hit_i) & EXT_BITS;
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr < A_MASK) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_addr == ADDR_W'(p / FIELDS_PER_REG))
          rd_val[SLOT_W*(p % FIELDS_PER_REG) +: CODE_W] = code_q[p];
      end
    end else if (bus_addr == A_MASK) begin
      rd_val[NUM_PINS-1:0] = mask_q;
    end else if (bus_addr == A_PEND) begin
      rd_val[NUM_PINS-1:0] = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      mask_q  <= EXT_BITS;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (cfg_en)  code_q  <= code_d;
      if (mask_en) mask_q  <= mask_d;
      pend_q <= pend_d;
      if (rd_req)  rdata_q <= rd_val;
    end
  end

  assign code_o    = code_q;
  assign mask_o    = mask_q;
  assign pend_o    = pend_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS       = 24,
  parameter int NUM_DIRECT     = 4,
  parameter int GRP_LO_LAST    = 7,
  parameter int FIELDS_PER_REG = 8,
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_DIRECT-1:0] direct_req_o,
  output logic                  grp_lo_req_o,
  output logic                  grp_hi_req_o
);
  logic                            rst_sync_n;
  logic [NUM_PINS-1:0]             lvl_vec, prev_vec, hit_vec;
  logic [NUM_PINS-1:0]             mask_vec, pend_vec, live_vec;
  logic [NUM_PINS-1:0][CODE_W-1:0] code_vec;
  logic [NUM_DIRECT-1:0]           direct_q, direct_d;

  ext_irq_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ext_irq_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_i),
    .lvl_o(lvl_vec), .prev_o(prev_vec)
  );

  ext_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .lvl_i(lvl_vec), .prev_i(prev_vec), .code_i(code_vec), .hit_o(hit_vec)
  );

  ext_irq_regs #(
    .NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT),
    .FIELDS_PER_REG(FIELDS_PER_REG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hit_i(hit_vec), .code_o(code_vec), .mask_o(mask_vec), .pend_o(pend_vec)
  );

  always_comb direct_d = hit_vec[NUM_DIRECT-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) direct_q <= '0;
    else             direct_q <= direct_d;
  end

  assign direct_req_o = direct_q;
  assign live_vec     = pend_vec & ~mask_vec;
  assign grp_lo_req_o = |live_vec[GRP_LO_LAST:NUM_DIRECT];
  assign grp_hi_req_o = |live_vec[NUM_PINS-1:GRP_LO_LAST+1];
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk #(
  parameter int NUM_PINS       = 24,
  parameter int NUM_DIRECT     = 4,
  parameter int GRP_LO_LAST    = 7,
  parameter int FIELDS_PER_REG = 8,
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_en,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] hit,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] mask,
  input logic                grp_lo,
  input logic                grp_hi
);
  localparam int NUM_CFG = (NUM_PINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NUM_CFG + 1);

  logic clr_wr;
  assign clr_wr = bus_en & bus_we & (bus_addr == A_PEND);

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend & $past(bus_wdata[NUM_PINS-1:0] & ~hit)) == '0)); // R5
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((~pend & $past(pend)) == '0)); // R5
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en || !bus_en |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R3
  AST_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask[GRP_LO_LAST:NUM_DIRECT]) |-> !grp_lo); // R6
  AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask[NUM_PINS-1:GRP_LO_LAST+1]) |-> !grp_hi); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(bus_rdata)); // R9
endmodule

bind ext_irq_front ext_irq_front_chk #(
  .NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT), .GRP_LO_LAST(GRP_LO_LAST),
  .FIELDS_PER_REG(FIELDS_PER_REG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .hit(hit_vec), .pend(pend_vec), .mask(mask_vec),
  .grp_lo(grp_lo_req_o), .grp_hi(grp_hi_req_o)
);

// File: tb/ext_irq_front_test.sv
module ext_irq_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pin_i;
  logic        bus_en, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  direct_req_o;
  logic        grp_lo_req_o, grp_hi_req_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] cfg_sh [3];
  logic [31:0] rv;

  ext_irq_front uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .direct_req_o(direct_req_o), .grp_lo_req_o(grp_lo_req_o),
    .grp_hi_req_o(grp_hi_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {pin[4:0], code[2:0], start level, end level, expected pending}
  localparam logic [10:0] VEC [11] = '{
    {5'd5,  3'd0, 1'b1, 1'b0, 1'b1},  // R3 low level hits
    {5'd5,  3'd0, 1'b1, 1'b1, 1'b0},  // R3 no match
    {5'd9,  3'd1, 1'b0, 1'b1, 1'b1},  // R3 high level hits
    {5'd9,  3'd1, 1'b0, 1'b0, 1'b0},  // R3 no match
    {5'd12, 3'd2, 1'b1, 1'b0, 1'b1},  // R4 falling
    {5'd12, 3'd3, 1'b0, 1'b1, 1'b0},  // R4 falling ignores rise, bit0 ignored
    {5'd16, 3'd4, 1'b0, 1'b1, 1'b1},  // R4 rising
    {5'd16, 3'd5, 1'b1, 1'b0, 1'b0},  // R4 rising ignores fall
    {5'd23, 3'd6, 1'b0, 1'b1, 1'b1},  // R4 both, rise
    {5'd23, 3'd7, 1'b1, 1'b0, 1'b1},  // R4 both, fall
    {5'd4,  3'd6, 1'b1, 1'b0, 1'b1}   // R4 both, lowest grouped line
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_code(input int p, input logic [2:0] c);
    cfg_sh[p/8][4*(p%8) +: 3] = c;
    wr(3'(p/8), cfg_sh[p/8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_i = '1; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    for (int i = 0; i < 3; i++) cfg_sh[i] = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 direct", {28'd0, direct_req_o}, 32'd0);
    check("R1 groups", {30'd0, grp_hi_req_o, grp_lo_req_o}, 32'd0);
    for (int a = 0; a < 3; a++) begin
      rd(3'(a), rv); check("R1 cfg", rv, 32'd0);
    end
    rd(3'd3, rv); check("R1 mask", rv, 32'h00FF_FFF0);
    rd(3'd4, rv); check("R1 pend", rv, 32'd0);

    // R2 field layout
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, rv); check("R2 cfg1 nibble bit3", rv, 32'h7777_7777);
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, rv); check("R2 cfg2 layout", rv, 32'h1234_5670);
    wr(3'd1, 32'd0); wr(3'd2, 32'd0);
    tick(4);
    wr(3'd4, 32'hFFFF_FFFF);

    // R9 unmapped address
    rd(3'd6, rv); check("R9 unmapped", rv, 32'd0);

    // Vector walk: R3, R4, R7
    wr(3'd3, 32'd0);
    rd(3'd3, rv); check("R6 mask cleared, bits 0-3 zero", rv, 32'd0);
    for (int v = 0; v < 11; v++) begin
      int p;
      logic [2:0] c;
      logic s, e, x;
      p = int'(VEC[v][10:6]); c = VEC[v][5:3];
      s = VEC[v][2]; e = VEC[v][1]; x = VEC[v][0];
      @(negedge clk); pin_i[p] = s;
      set_code(p, c);
      tick(6);
      wr(3'd4, 32'hFFFF_FFFF);
      tick(2);
      pin_i[p] = e;
      tick(6);
      check("R7 group output", {31'd0, (p < 8) ? grp_lo_req_o : grp_hi_req_o}, {31'd0, x});
      rd(3'd4, rv);
      check((c[2:1] == 2'b00) ? "R3 level pend" : "R4 edge pend", {31'd0, rv[p]}, {31'd0, x});
      pin_i[p] = 1'b1;
      set_code(p, 3'd0);
      tick(6);
      wr(3'd4, 32'hFFFF_FFFF);
    end

    // R8 direct line, rising edge pulse timing
    set_code(2, 3'd4);
    @(negedge clk); pin_i[2] = 1'b0;
    tick(6);
    check("R8 fall ignored in rise mode", {28'd0, direct_req_o}, 32'd0);
    pin_i[2] = 1'b1;
    tick(2);
    check("R8 not before third edge", {28'd0, direct_req_o}, 32'd0);
    tick(1);
    check("R8 pulse at third edge", {28'd0, direct_req_o}, 32'h4);
    tick(1);
    check("R8 pulse one cycle", {28'd0, direct_req_o}, 32'd0);
    rd(3'd4, rv); check("R8 no pending for direct lines", rv, 32'd0);
    check("R8 groups untouched", {30'd0, grp_hi_req_o, grp_lo_req_o}, 32'd0);
    set_code(2, 3'd0);
    // R8 direct level
    @(negedge clk); pin_i[0] = 1'b0;
    tick(8);
    check("R8 level holds direct", {28'd0, direct_req_o}, 32'h1);
    pin_i[0] = 1'b1;
    tick(4);
    check("R8 level released", {28'd0, direct_req_o}, 32'd0);

    // R6 masked line still records
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, rv); check("R6 mask write", rv, 32'h00FF_FFF0);
    set_code(6, 3'd4);
    @(negedge clk); pin_i[6] = 1'b0;
    tick(6);
    wr(3'd4, 32'hFFFF_FFFF);
    pin_i[6] = 1'b1;
    tick(6);
    check("R6 masked group low", {31'd0, grp_lo_req_o}, 32'd0);
    rd(3'd4, rv); check("R6 masked pend recorded", rv, 32'h0000_0040);
    wr(3'd3, ~32'h0000_0040);
    check("R7 unmask raises group", {31'd0, grp_lo_req_o}, 32'd1);
    wr(3'd4, 32'd0);
    rd(3'd4, rv); check("R5 write zero keeps", rv, 32'h0000_0040);
    wr(3'd4, 32'h0000_0040);
    check("R5 clear drops group", {31'd0, grp_lo_req_o}, 32'd0);
    rd(3'd4, rv); check("R5 cleared", rv, 32'd0);
    set_code(6, 3'd0);

    // R3 level re-sets after clear
    @(negedge clk); pin_i[10] = 1'b0;
    tick(6);
    wr(3'd4, 32'h0000_0400);
    tick(2);
    rd(3'd4, rv); check("R3 re-set after clear", rv, 32'h0000_0400);
    check("R6 masked hi group low", {31'd0, grp_hi_req_o}, 32'd0);
    pin_i[10] = 1'b1;
    tick(4);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, rv); check("R5 clear after release", rv, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule